// File: doc/BRIEF.md
# Cycle-Steal Memory Arbiter

This block lets a set of I/O devices borrow single memory cycles from a processor. While no device wants the memory, the processor's clock enable stays high and the processor owns the bus. When one or more devices raise their request at a memory-cycle boundary, the arbiter picks one winner by fixed priority. It pulls the processor clock enable low for exactly one cycle and uses that cycle to move one word between the winner and memory. In the following cycle it acknowledges the device and hands the bus back to the processor. Between two steals the processor always gets at least one cycle of its own, so device transfers interleave with program execution and with each other.

Each device has a programmable minimum spacing between two of its own steals. This lets slow devices be paced so they disturb the processor as little as possible, while fast devices can be given a short spacing. A request made inside a device's spacing window is not lost. It waits, and it does not block lower-priority devices that are ready. A running count of stolen cycles is provided for observation.

The controller has three states. `ST_RUN` is the processor cycle in which grants are decided. `ST_STEAL` is the stolen memory cycle. `ST_RELEASE` is the acknowledge cycle in which the processor runs again. The transitions are:
- `ST_RUN` → `ST_STEAL` when some device is both requesting and outside its spacing window.
- `ST_RUN` → `ST_RUN` otherwise.
- `ST_STEAL` → `ST_RELEASE` always.
- `ST_RELEASE` → `ST_RUN` always.

Top module: `cs_steal_arbiter`

## Requirements
- R1: After reset `cpu_ce` is 1, `mem_en` is 0, `dev_ack` is all zeros and `steal_count` is 0.
- R2: With no device requesting, `cpu_ce` stays 1 and `mem_en` stays 0.
- R3: An eligible request seen at a decision edge causes, in the next cycle, exactly one cycle with `cpu_ce`=0 and `mem_en`=1. In that cycle `mem_addr`, `mem_we` and `mem_wdata` carry the winner's address, direction and write data.
- R4: Among eligible requesters, the lowest device index wins (device 0 is highest priority).
- R5: In the cycle after the stolen cycle, `dev_ack` is one-hot on the winner for one cycle. For a read (`dev_we`=0), `dev_rdata` holds the word at the winner's address in that cycle.
- R6: `cpu_ce` is 1 in the cycle after every stolen cycle. Two stolen cycles are at least 3 cycles apart.
- R7: With spacing value G on a device, that device's consecutive stolen cycles are max(3, G+1) cycles apart when its request is held high.
- R8: A request held back by its spacing window does not stop a lower-priority eligible device from being served. The waiting device is served once its window ends.
- R9: `steal_count` increases by one for each stolen cycle and is otherwise unchanged.
- R10: For a write (`dev_we`=1), `mem_we` is 1 in the stolen cycle and the word is stored in memory by the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | N_DEV | Per-device steal request, held until acknowledged |
| dev_we | input | N_DEV | Per-device direction, 1 = write to memory |
| dev_addr | input | N_DEV*AW | Per-device word address, device i at bits [i*AW +: AW] |
| dev_wdata | input | N_DEV*DW | Per-device write word, device i at bits [i*DW +: DW] |
| dev_gap | input | N_DEV*GW | Per-device minimum spacing G, device i at bits [i*GW +: GW] |
| dev_ack | output | N_DEV | One-cycle acknowledge to the served device |
| dev_rdata | output | DW | Read word, valid with the acknowledge |
| cpu_ce | output | 1 | Processor clock enable, 0 during a stolen cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write word |
| mem_rdata | input | DW | Memory read word, one cycle after the strobe |
| steal_count | output | CW | Total stolen cycles, wrapping |

## Verification
The bench drives every request pattern, from a single device up to all four. A priority encoder scanning in the wrong direction would serve the wrong device and acknowledge the wrong device. With a device's request held high, the bench measures the distance between its acknowledges. An off-by-one in the spacing counter would show up as a spacing of G or G+2 instead of G+1. A controller that skipped the release cycle would produce steals closer than three cycles apart. The bench also pairs a paced high-priority device with an unpaced low-priority one and checks the served order. A window that blocked the whole arbiter, instead of just its own device, would stall the low-priority device. The bench keeps its own tally of cycles with the processor held and compares it with `steal_count` at the end.

// File: rtl/cs_steal_pkg.sv
package cs_steal_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STEAL   = 2'd1,
        ST_RELEASE = 2'd2
    } steal_state_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
    parameter int unsigned N_DEV = 4,
    localparam int unsigned IW = cs_steal_pkg::idx_width(N_DEV)
) (
    input  logic [N_DEV-1:0] elig,
    output logic             win_valid,
    output logic [IW-1:0]    win_idx
);

    // scan from the lowest priority upward so the lowest index is kept last
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/cs_pace_timer.sv
module cs_pace_timer #(
    parameter int unsigned GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] gap,
    output logic          ready
);

    logic [GW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= gap;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign ready = (remain_q == '0);

endmodule

// File: rtl/cs_steal_fsm.sv
module cs_steal_fsm
    import cs_steal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pick_valid,
    output logic grant_load,
    output logic cpu_ce,
    output logic mem_en,
    output logic ack_fire
);

    steal_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        grant_load = 1'b0;
        cpu_ce     = 1'b1;
        mem_en     = 1'b0;
        ack_fire   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (pick_valid) begin
                    grant_load = 1'b1;
                    state_d    = ST_STEAL;
                end
            end
            ST_STEAL: begin
                cpu_ce  = 1'b0;
                mem_en  = 1'b1;
                state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                ack_fire = 1'b1;
                state_d  = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

endmodule

// File: rtl/cs_steal_arbiter.sv
module cs_steal_arbiter #(
    parameter int unsigned N_DEV = 4,
    parameter int unsigned AW    = 12,
    parameter int unsigned DW    = 16,
    parameter int unsigned GW    = 8,
    parameter int unsigned CW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_DEV-1:0]    dev_req,
    input  logic [N_DEV-1:0]    dev_we,
    input  logic [N_DEV*AW-1:0] dev_addr,
    input  logic [N_DEV*DW-1:0] dev_wdata,
    input  logic [N_DEV*GW-1:0] dev_gap,
    output logic [N_DEV-1:0]    dev_ack,
    output logic [DW-1:0]       dev_rdata,
    output logic                cpu_ce,
    output logic                mem_en,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [DW-1:0]       mem_wdata,
    input  logic [DW-1:0]       mem_rdata,
    output logic [CW-1:0]       steal_count
);

    localparam int unsigned IW = cs_steal_pkg::idx_width(N_DEV);

    logic [N_DEV-1:0] ready;
    logic [N_DEV-1:0] elig;
    logic [N_DEV-1:0] load_vec;
    logic             pick_valid;
    logic [IW-1:0]    pick_idx;
    logic             grant_load;
    logic             ack_fire;

    logic [IW-1:0]    win_q;
    logic             we_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [CW-1:0]    count_q;

    // one spacing timer per device, reloaded when that device wins
    for (genvar g = 0; g < N_DEV; g++) begin : g_pace
        assign load_vec[g] = grant_load && (pick_idx == IW'(g));
        cs_pace_timer #(.GW(GW)) u_pace (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_vec[g]),
            .gap   (dev_gap[g*GW +: GW]),
            .ready (ready[g])
        );
    end

    assign elig = dev_req & ready;

    cs_prio_pick #(.N_DEV(N_DEV)) u_pick (
        .elig      (elig),
        .win_valid (pick_valid),
        .win_idx   (pick_idx)
    );

    cs_steal_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick_valid (pick_valid),
        .grant_load (grant_load),
        .cpu_ce     (cpu_ce),
        .mem_en     (mem_en),
        .ack_fire   (ack_fire)
    );

    // capture the winner's transfer at the decision edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (grant_load) begin
            win_q   <= pick_idx;
            we_q    <= dev_we[pick_idx];
            addr_q  <= dev_addr[pick_idx*AW +: AW];
            wdata_q <= dev_wdata[pick_idx*DW +: DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (mem_en) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign mem_we      = mem_en && we_q;
    assign mem_addr    = addr_q;
    assign mem_wdata   = wdata_q;
    assign dev_ack     = ack_fire ? (N_DEV'(1) << win_q) : '0;
    assign dev_rdata   = mem_rdata;
    assign steal_count = count_q;

endmodule

// File: rtl/cs_steal_checker.sv
module cs_steal_checker #(
    parameter int unsigned N_DEV = 4,
    parameter int unsigned CW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ce,
    input logic             mem_en,
    input logic [N_DEV-1:0] dev_ack,
    input logic [CW-1:0]    steal_count
);

    AST_CE_LOW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) !cpu_ce |=> cpu_ce); // R6
    AST_STEAL_HAS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !cpu_ce |-> mem_en); // R3
    AST_ACCESS_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n) mem_en |-> !cpu_ce); // R3
    AST_ACK_FOLLOWS_STEAL: assert property (@(posedge clk) disable iff (!rst_n) mem_en |=> $countones(dev_ack) == 1); // R5
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(dev_ack)); // R5
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n) (|dev_ack) |-> !mem_en); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) mem_en |=> steal_count == $past(steal_count) + 1'b1); // R9
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mem_en |=> $stable(steal_count)); // R9

endmodule

bind cs_steal_arbiter cs_steal_checker #(.N_DEV(N_DEV), .CW(CW)) u_steal_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_ce      (cpu_ce),
    .mem_en      (mem_en),
    .dev_ack     (dev_ack),
    .steal_count (steal_count)
);

// File: tb/test_cs_steal_arbiter.sv
module test_cs_steal_arbiter;

    localparam int N  = 4;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int GW = 8;
    localparam int CW = 16;

    // {request mask, write mask, expected winner}
    localparam logic [11:0] VECS [0:7] = '{
        12'h100, 12'h221, 12'h601, 12'hC42,
        12'h803, 12'hFF0, 12'hA01, 12'h442
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      dev_req = '0;
    logic [N-1:0]      dev_we = '0;
    logic [N*AW-1:0]   dev_addr = '0;
    logic [N*DW-1:0]   dev_wdata = '0;
    logic [N*GW-1:0]   dev_gap = '0;
    logic [N-1:0]      dev_ack;
    logic [DW-1:0]     dev_rdata;
    logic              cpu_ce;
    logic              mem_en;
    logic              mem_we;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_wdata;
    logic [DW-1:0]     mem_rdata;
    logic [CW-1:0]     steal_count;

    logic [DW-1:0] mem [0:15];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int held = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cs_steal_arbiter #(.N_DEV(N), .AW(AW), .DW(DW), .GW(GW), .CW(CW)) i_cs_steal_arbiter (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_we(dev_we),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_gap(dev_gap),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata), .cpu_ce(cpu_ce),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .steal_count(steal_count)
    );

    // memory model: synchronous write, one-cycle read
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 16; a++) mem[a] <= 16'h5A00 + 16'(a);
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[3:0]];
        end
    end

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n && cpu_ce === 1'b0) held <= held + 1;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_ack(output int who, output int when);
        who = -1;
        when = -1;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (dev_ack != '0) begin
                for (int d = 0; d < N; d++) if (dev_ack[d]) who = d;
                when = cyc;
                return;
            end
        end
    endtask

    task automatic measure_gap(input int dev, input int g, input int expd, input string rq);
        int w0, t0, w1, t1;
        dev_gap = '0;
        dev_gap[dev*GW +: GW] = GW'(g);
        dev_we = '0;
        dev_addr = '0;
        dev_addr[dev*AW +: AW] = AW'(dev);
        dev_req = '0;
        dev_req[dev] = 1'b1;
        wait_ack(w0, t0);
        for (int s = 0; s < 2; s++) begin
            wait_ack(w1, t1);
            chk(w1 == dev && (t1 - t0) == expd, rq, $sformatf("spacing gap=%0d", g),
                32'(t1 - t0), 32'(expd));
            t0 = t1;
        end
        dev_req = '0;
        repeat (g + 4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cpu_ce === 1'b1 && mem_en === 1'b0 && dev_ack === '0 && steal_count === '0,
            "R1", "reset outputs", {cpu_ce, mem_en, 2'b0, dev_ack, 8'(steal_count)}, 32'h8000_0000 >> 30);
        rst_n = 1'b1;

        // R2: idle, processor keeps running
        begin
            bit ok = 1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (cpu_ce !== 1'b1 || mem_en !== 1'b0) ok = 0;
            end
            chk(ok, "R2", "idle cpu_ce/mem_en", {31'b0, ok}, 32'd1);
        end

        // table walk: R3 R4 R5 R10
        for (int v = 0; v < 8; v++) begin
            logic [3:0] rq, wm;
            int ex;
            logic [DW-1:0] wd;
            rq = VECS[v][11:8];
            wm = VECS[v][7:4];
            ex = int'(VECS[v][3:0]);
            dev_req = rq;
            dev_we = wm;
            for (int d = 0; d < N; d++) begin
                dev_addr[d*AW +: AW] = wm[d] ? AW'(8 + d) : AW'(d);
                dev_wdata[d*DW +: DW] = 16'hC000 + 16'(v * 16 + d);
            end
            wd = 16'hC000 + 16'(v * 16 + ex);
            @(negedge clk);
            chk(cpu_ce === 1'b0 && mem_en === 1'b1, "R3", $sformatf("vec %0d stall", v),
                {30'b0, cpu_ce, mem_en}, 32'd1);
            chk(mem_addr === (wm[ex] ? AW'(8 + ex) : AW'(ex)) && mem_we === wm[ex], "R4",
                $sformatf("vec %0d winner address", v), {19'b0, mem_we, mem_addr},
                {19'b0, wm[ex], (wm[ex] ? AW'(8 + ex) : AW'(ex))});
            if (wm[ex]) chk(mem_wdata === wd, "R3", $sformatf("vec %0d wdata", v), 32'(mem_wdata), 32'(wd));
            @(negedge clk);
            chk(dev_ack === N'(1 << ex), "R5", $sformatf("vec %0d ack", v), 32'(dev_ack), 32'(1 << ex));
            chk(cpu_ce === 1'b1, "R6", $sformatf("vec %0d release", v), 32'(cpu_ce), 32'd1);
            if (wm[ex])
                chk(mem[8 + ex] === wd, "R10", $sformatf("vec %0d stored", v), 32'(mem[8 + ex]), 32'(wd));
            else
                chk(dev_rdata === 16'h5A00 + 16'(ex), "R5", $sformatf("vec %0d rdata", v),
                    32'(dev_rdata), 32'(16'h5A00 + 16'(ex)));
            dev_req = '0;
            @(negedge clk);
        end
        dev_we = '0;
        repeat (3) @(negedge clk);

        // R6 / R7: spacing under held requests
        measure_gap(2, 0, 3, "R6");
        measure_gap(1, 2, 3, "R7");
        measure_gap(2, 5, 6, "R7");
        measure_gap(3, 9, 10, "R7");

        // R8: paced device 0 must not stall device 3
        begin
            int who, when;
            int exp_seq [0:4] = '{0, 3, 3, 3, 0};
            dev_gap = '0;
            dev_gap[0*GW +: GW] = GW'(10);
            dev_addr = '0;
            dev_addr[3*AW +: AW] = AW'(3);
            dev_req = 4'b1001;
            for (int s = 0; s < 5; s++) begin
                wait_ack(who, when);
                chk(who == exp_seq[s], "R8", $sformatf("order step %0d", s), 32'(who), 32'(exp_seq[s]));
            end
            dev_req = '0;
            repeat (14) @(negedge clk);
        end

        // R9: stolen-cycle tally
        chk(steal_count === CW'(held), "R9", "steal_count", 32'(steal_count), 32'(held));

        finish_run();
    end

endmodule